// File: doc/BRIEF.md
# Collision-Free Line Group Builder

This block runs once, the first time the chip asks to drop its supply into the low-voltage region. It sequences the entry steps in a fixed order. First it starts the cache self-test and waits for it to finish. Then it asks the processor to go back to high-voltage operation and waits for the acknowledge. Only then does it accept one fault vector per cache line, in line-index order, with one bit per chunk and a set bit marking a faulty chunk.

Each line joins a group. No two members of a group may have a faulty chunk at the same bit position, which means the bitwise AND of any two member vectors is zero. Every group gets one sacrificial line, whose healthy chunks stand in for the faulty chunks of the other members. The block hands the results to the remapper over two outgoing streams: one memory-map entry per line, then one fault-map entry per group. After that it holds a sticky done flag.

The remapping scheme applies only while the supply reading is below the low-voltage limit, 651 mV by default. At or above the limit the scheme stays off.

All three streams use valid/ready. A beat transfers on a rising edge where both valid and ready are high. While valid is high and ready is low, the sender holds the beat unchanged. The fault-vector input may stall between lines for any number of cycles. Both map outputs accept back-pressure of any length.

Top module: `line_group_builder`

## Requirements
- R1: A `lp_req` pulse seen in the idle state while `vdd_mv` is below `VDD_LIMIT_MV` raises `bist_start`. `bist_start` stays high until `bist_done`. Then `hp_req` stays high until `hp_ack`. Only after that does `flt_ready` go high. A request made while `vdd_mv >= VDD_LIMIT_MV` starts nothing.
- R2: No two lines placed in the same group have a set bit at the same position of their fault vectors.
- R3: Lines are placed in index order. Each line goes to the lowest-numbered existing group that is not full and whose members do not collide with it. If there is no such group, it opens a new group whose number is the current group count.
- R4: A group never holds more than `GRP_MAX` lines. A full group accepts no further lines.
- R5: A line with an all-zero fault vector joins the lowest-numbered group that is not full.
- R6: A line that fits no existing group when all `GROUPS` groups are already open is disabled. Its memory-map beat carries `mm_dis`=1, and `dis_count` equals the number of such lines.
- R7: Each group's sacrificial line is the member with the fewest set bits; on a tie it is the lowest index. Its memory-map beat carries `mm_sac`=1, and every other enabled line carries `mm_sac`=0.
- R8: The memory map is sent as exactly `LINES` beats in line order 0..LINES-1. Each beat carries the line's group number in `mm_group`. A stalled beat holds all of its fields.
- R9: The fault map is sent as one beat per opened group, in order 0..count-1. Each beat carries the sacrificial line in `fm_sac_line` and, in `fm_cover`, the OR of the fault vectors of the group's other members. A stalled beat holds all of its fields.
- R10: `done` goes high on the edge that completes the last fault-map beat and stays high. It is never high earlier. After it rises, the block accepts no fault vector and starts no new test.
- R11: `lp_req` pulses that arrive while grouping or map output is in progress are ignored. They neither start a test nor change the result.
- R12: `remap_en` is high only when `done` is high and `vdd_mv < VDD_LIMIT_MV`. At exactly the limit it is low.

Ports follow the top module's port list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vdd_mv | input | VW | Present supply reading in millivolts |
| lp_req | input | 1 | Request to enter low-voltage mode |
| bist_start | output | 1 | Run the cache self-test (level, held until `bist_done`) |
| bist_done | input | 1 | Self-test has finished |
| hp_req | output | 1 | Ask the processor to return to high-voltage mode |
| hp_ack | input | 1 | Processor is back in high-voltage mode |
| flt_valid | input | 1 | Fault vector beat valid |
| flt_ready | output | 1 | Builder accepts a fault vector |
| flt_vec | input | CHUNKS | Faulty-chunk bits of the next line in index order |
| mm_valid | output | 1 | Memory-map beat valid |
| mm_ready | input | 1 | Memory map accepts the beat |
| mm_line | output | LW | Line index of the beat |
| mm_group | output | GW | Group number of the line (0 when disabled) |
| mm_sac | output | 1 | Line is its group's sacrificial line |
| mm_dis | output | 1 | Line is disabled |
| fm_valid | output | 1 | Fault-map beat valid |
| fm_ready | input | 1 | Fault map accepts the beat |
| fm_grp | output | GW | Group number of the beat |
| fm_sac_line | output | LW | Sacrificial line of the group |
| fm_cover | output | CHUNKS | Chunk positions the sacrificial line supplies |
| done | output | 1 | All map beats have been delivered (sticky) |
| remap_en | output | 1 | Remapping active at the present supply |
| dis_count | output | LW+1 | Number of disabled lines |

## Verification
Several properties are checked on every cycle. A line never joins a group it collides with. No group grows past its cap. A line is disabled only when every group is open. The entry handshakes occur in order. Stalled map beats hold steady. `done` is sticky. A fault-map beat always names a sacrificial line that belongs to that group.

Other behaviours can only be shown by the bench's scenarios. These are the first-fit choice of group, the fewest-faults choice of sacrificial line with lowest-index tie-break, the exact cover vectors, and the count of disabled lines. The bench compares them against a reference grouping computed from each scenario's fault vectors. It also covers the supply threshold and the ignoring of requests made mid-build.

// File: rtl/lgb_pkg.sv
package lgb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TEST,
    PH_WAKE,
    PH_BUILD,
    PH_MMAP,
    PH_FMAP,
    PH_DONE
  } lgb_phase_e;
endpackage

// File: rtl/lgb_fit_search.sv
// First-fit search: lowest open group that is not full and has no shared faulty chunk.
module lgb_fit_search #(
  parameter int CHUNKS  = 8,
  parameter int GROUPS  = 6,
  parameter int GRP_MAX = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int SW = $clog2(GRP_MAX + 1)
) (
  input  logic [CHUNKS-1:0]              cand_vec,
  input  logic [GROUPS-1:0][CHUNKS-1:0]  grp_union,
  input  logic [GROUPS-1:0][SW-1:0]      grp_size,
  input  logic [GW:0]                    grp_used,
  output logic                           fit_hit,
  output logic [GW-1:0]                  fit_grp
);
  logic [GROUPS-1:0] fits;

  for (genvar g = 0; g < GROUPS; g++) begin : g_fit
    assign fits[g] = ((GW+1)'(g) < grp_used)
                  && (grp_size[g] < SW'(GRP_MAX))
                  && ((grp_union[g] & cand_vec) == '0);
  end

  always_comb begin
    fit_hit = |fits;
    fit_grp = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (fits[g]) fit_grp = GW'(g);
    end
  end
endmodule

// File: rtl/lgb_line_store.sv
// Per-line and per-group state built up as fault vectors arrive.
module lgb_line_store #(
  parameter int LINES   = 16,
  parameter int CHUNKS  = 8,
  parameter int GROUPS  = 6,
  parameter int GRP_MAX = 4,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int SW = $clog2(GRP_MAX + 1),
  localparam int CW = $clog2(CHUNKS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [LW-1:0]                  wr_line,
  input  logic [CHUNKS-1:0]              wr_vec,
  input  logic                           wr_new,
  input  logic                           wr_dis,
  input  logic [GW-1:0]                  wr_grp,
  output logic [GROUPS-1:0][CHUNKS-1:0]  grp_union,
  output logic [GROUPS-1:0][SW-1:0]      grp_size,
  output logic [GROUPS-1:0][LW-1:0]      grp_sac,
  output logic [GW:0]                    grp_used,
  output logic [LINES-1:0][CHUNKS-1:0]   line_vec,
  output logic [LINES-1:0][GW-1:0]       line_grp,
  output logic [LINES-1:0]               line_dis,
  output logic [LW:0]                    dis_cnt
);
  logic [GROUPS-1:0][CW-1:0] sac_wt;
  logic [CW-1:0]             wr_wt;

  assign wr_wt = CW'($countones(wr_vec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_union <= '0;
      grp_size  <= '0;
      grp_sac   <= '0;
      sac_wt    <= '0;
      grp_used  <= '0;
      line_vec  <= '0;
      line_grp  <= '0;
      line_dis  <= '0;
      dis_cnt   <= '0;
    end else if (wr_en) begin
      line_vec[wr_line] <= wr_vec;
      line_dis[wr_line] <= wr_dis;
      line_grp[wr_line] <= wr_dis ? '0 : wr_grp;
      if (wr_dis) begin
        dis_cnt <= dis_cnt + 1'b1;
      end else begin
        grp_union[wr_grp] <= wr_new ? wr_vec : (grp_union[wr_grp] | wr_vec);
        grp_size[wr_grp]  <= wr_new ? SW'(1) : (grp_size[wr_grp] + 1'b1);
        if (wr_new) begin
          grp_used        <= grp_used + 1'b1;
          grp_sac[wr_grp] <= wr_line;
          sac_wt[wr_grp]  <= wr_wt;
        end else if (wr_wt < sac_wt[wr_grp]) begin
          grp_sac[wr_grp] <= wr_line;
          sac_wt[wr_grp]  <= wr_wt;
        end
      end
    end
  end

  AST_NO_SHARED_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_dis && !wr_new) |-> ((grp_union[wr_grp] & wr_vec) == '0)); // R2

  AST_NEW_GROUP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_new) |-> ({1'b0, wr_grp} == grp_used)); // R3

  AST_DISABLE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dis) |-> (grp_used == (GW+1)'(GROUPS))); // R6

  for (genvar g = 0; g < GROUPS; g++) begin : g_cap
    AST_GROUP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      grp_size[g] <= SW'(GRP_MAX)); // R4
  end
endmodule

// File: rtl/lgb_phase_ctl.sv
// Entry sequencing, fault-vector intake and map streaming.
module lgb_phase_ctl
  import lgb_pkg::*;
#(
  parameter int LINES        = 16,
  parameter int GROUPS       = 6,
  parameter int VW           = 12,
  parameter int VDD_LIMIT_MV = 651,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vdd_mv,
  input  logic          lp_req,
  input  logic          bist_done,
  input  logic          hp_ack,
  input  logic          flt_valid,
  input  logic          mm_ready,
  input  logic          fm_ready,
  input  logic          fit_hit,
  input  logic [GW-1:0] fit_grp,
  input  logic [GW:0]   grp_used,
  output logic          bist_start,
  output logic          hp_req,
  output logic          flt_ready,
  output logic          wr_en,
  output logic [LW-1:0] wr_line,
  output logic          wr_new,
  output logic          wr_dis,
  output logic [GW-1:0] wr_grp,
  output logic          mm_valid,
  output logic [LW-1:0] mm_line,
  output logic          fm_valid,
  output logic [GW-1:0] fm_grp,
  output logic          done
);
  lgb_phase_e    phase_q, phase_d;
  logic [LW-1:0] line_q;
  logic [GW-1:0] grp_q;
  logic          below, flt_hs, mm_hs, fm_hs, last_line, last_grp, has_room;

  assign below     = vdd_mv < VW'(VDD_LIMIT_MV);
  assign bist_start = (phase_q == PH_TEST);
  assign hp_req    = (phase_q == PH_WAKE);
  assign flt_ready = (phase_q == PH_BUILD);
  assign mm_valid  = (phase_q == PH_MMAP);
  assign fm_valid  = (phase_q == PH_FMAP);
  assign done      = (phase_q == PH_DONE);

  assign flt_hs    = flt_valid && flt_ready;
  assign mm_hs     = mm_valid && mm_ready;
  assign fm_hs     = fm_valid && fm_ready;
  assign last_line = (line_q == LW'(LINES - 1));
  assign last_grp  = ({1'b0, grp_q} == (grp_used - 1'b1));
  assign has_room  = grp_used < (GW+1)'(GROUPS);

  assign wr_en   = flt_hs;
  assign wr_line = line_q;
  assign wr_new  = !fit_hit && has_room;
  assign wr_dis  = !fit_hit && !has_room;
  assign wr_grp  = fit_hit ? fit_grp : grp_used[GW-1:0];
  assign mm_line = line_q;
  assign fm_grp  = grp_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (lp_req && below)         phase_d = PH_TEST;
      PH_TEST:  if (bist_done)               phase_d = PH_WAKE;
      PH_WAKE:  if (hp_ack)                  phase_d = PH_BUILD;
      PH_BUILD: if (flt_hs && last_line)     phase_d = PH_MMAP;
      PH_MMAP:  if (mm_hs && last_line)      phase_d = PH_FMAP;
      PH_FMAP:  if (fm_hs && last_grp)       phase_d = PH_DONE;
      PH_DONE:                               phase_d = PH_DONE;
      default:                               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      line_q  <= '0;
      grp_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (flt_hs || mm_hs) line_q <= last_line ? '0 : (line_q + 1'b1);
      if (fm_hs)           grp_q  <= grp_q + 1'b1;
    end
  end

  AST_TEST_THEN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_req) |-> $past(bist_start && bist_done)); // R1

  AST_WAKE_THEN_BUILD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_ready) |-> $past(hp_req && hp_ack)); // R1

  AST_MM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_valid && !mm_ready) |=> (mm_valid && $stable(mm_line))); // R8

  AST_FM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_valid && !fm_ready) |=> (fm_valid && $stable(fm_grp))); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !flt_ready && !bist_start)); // R10

  AST_IGNORE_MIDBUILD: assert property (@(posedge clk) disable iff (!rst_n)
    ((flt_ready || mm_valid || fm_valid) && lp_req) |=> !bist_start); // R11
endmodule

// File: rtl/line_group_builder.sv
module line_group_builder #(
  parameter int LINES        = 16,
  parameter int CHUNKS       = 8,
  parameter int GROUPS       = 6,
  parameter int GRP_MAX      = 4,
  parameter int VW           = 12,
  parameter int VDD_LIMIT_MV = 651,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int SW = $clog2(GRP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VW-1:0]     vdd_mv,
  input  logic              lp_req,
  output logic              bist_start,
  input  logic              bist_done,
  output logic              hp_req,
  input  logic              hp_ack,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [CHUNKS-1:0] flt_vec,
  output logic              mm_valid,
  input  logic              mm_ready,
  output logic [LW-1:0]     mm_line,
  output logic [GW-1:0]     mm_group,
  output logic              mm_sac,
  output logic              mm_dis,
  output logic              fm_valid,
  input  logic              fm_ready,
  output logic [GW-1:0]     fm_grp,
  output logic [LW-1:0]     fm_sac_line,
  output logic [CHUNKS-1:0] fm_cover,
  output logic              done,
  output logic              remap_en,
  output logic [LW:0]       dis_count
);
  logic [GROUPS-1:0][CHUNKS-1:0] grp_union;
  logic [GROUPS-1:0][SW-1:0]     grp_size;
  logic [GROUPS-1:0][LW-1:0]     grp_sac;
  logic [GW:0]                   grp_used;
  logic [LINES-1:0][CHUNKS-1:0]  line_vec;
  logic [LINES-1:0][GW-1:0]      line_grp;
  logic [LINES-1:0]              line_dis;
  logic                          fit_hit, wr_en, wr_new, wr_dis;
  logic [GW-1:0]                 fit_grp, wr_grp;
  logic [LW-1:0]                 wr_line;

  lgb_fit_search #(.CHUNKS(CHUNKS), .GROUPS(GROUPS), .GRP_MAX(GRP_MAX)) u_fit (
    .cand_vec (flt_vec),
    .grp_union(grp_union),
    .grp_size (grp_size),
    .grp_used (grp_used),
    .fit_hit  (fit_hit),
    .fit_grp  (fit_grp)
  );

  lgb_line_store #(.LINES(LINES), .CHUNKS(CHUNKS), .GROUPS(GROUPS), .GRP_MAX(GRP_MAX)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_line  (wr_line),
    .wr_vec   (flt_vec),
    .wr_new   (wr_new),
    .wr_dis   (wr_dis),
    .wr_grp   (wr_grp),
    .grp_union(grp_union),
    .grp_size (grp_size),
    .grp_sac  (grp_sac),
    .grp_used (grp_used),
    .line_vec (line_vec),
    .line_grp (line_grp),
    .line_dis (line_dis),
    .dis_cnt  (dis_count)
  );

  lgb_phase_ctl #(.LINES(LINES), .GROUPS(GROUPS), .VW(VW), .VDD_LIMIT_MV(VDD_LIMIT_MV)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vdd_mv    (vdd_mv),
    .lp_req    (lp_req),
    .bist_done (bist_done),
    .hp_ack    (hp_ack),
    .flt_valid (flt_valid),
    .mm_ready  (mm_ready),
    .fm_ready  (fm_ready),
    .fit_hit   (fit_hit),
    .fit_grp   (fit_grp),
    .grp_used  (grp_used),
    .bist_start(bist_start),
    .hp_req    (hp_req),
    .flt_ready (flt_ready),
    .wr_en     (wr_en),
    .wr_line   (wr_line),
    .wr_new    (wr_new),
    .wr_dis    (wr_dis),
    .wr_grp    (wr_grp),
    .mm_valid  (mm_valid),
    .mm_line   (mm_line),
    .fm_valid  (fm_valid),
    .fm_grp    (fm_grp),
    .done      (done)
  );

  // Map beat fields read from the store at the stream counters.
  assign mm_dis      = line_dis[mm_line];
  assign mm_group    = line_grp[mm_line];
  assign mm_sac      = !mm_dis && (grp_sac[mm_group] == mm_line);
  assign fm_sac_line = grp_sac[fm_grp];
  assign fm_cover    = grp_union[fm_grp] & ~line_vec[fm_sac_line];
  assign remap_en    = done && (vdd_mv < VW'(VDD_LIMIT_MV));

  AST_SAC_IS_MEMBER: assert property (@(posedge clk) disable iff (!rst_n)
    fm_valid |-> (!line_dis[fm_sac_line] && (line_grp[fm_sac_line] == fm_grp))); // R7
endmodule

// File: tb/line_group_builder_bench.sv
module line_group_builder_bench;
  localparam int LINES = 16, CHUNKS = 8, GROUPS = 6, GRP_MAX = 4;
  localparam int LW = 4, GW = 3, VW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lp_req, bist_done, hp_ack, flt_valid, mm_ready, fm_ready;
  logic [VW-1:0] vdd_mv;
  logic [CHUNKS-1:0] flt_vec;
  logic bist_start, hp_req, flt_ready, mm_valid, mm_sac, mm_dis, fm_valid, done, remap_en;
  logic [LW-1:0] mm_line, fm_sac_line;
  logic [GW-1:0] mm_group, fm_grp;
  logic [CHUNKS-1:0] fm_cover;
  logic [LW:0] dis_count;

  line_group_builder u_line_group_builder (
    .clk(clk), .rst_n(rst_n), .vdd_mv(vdd_mv), .lp_req(lp_req),
    .bist_start(bist_start), .bist_done(bist_done), .hp_req(hp_req), .hp_ack(hp_ack),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_vec(flt_vec),
    .mm_valid(mm_valid), .mm_ready(mm_ready), .mm_line(mm_line), .mm_group(mm_group),
    .mm_sac(mm_sac), .mm_dis(mm_dis),
    .fm_valid(fm_valid), .fm_ready(fm_ready), .fm_grp(fm_grp), .fm_sac_line(fm_sac_line),
    .fm_cover(fm_cover), .done(done), .remap_en(remap_en), .dis_count(dis_count)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [CHUNKS-1:0] ev [LINES];
  int eg [LINES];
  bit ed [LINES];
  logic [CHUNKS-1:0] gunion [GROUPS];
  int gsize [GROUPS], gsac [GROUPS], gwt [GROUPS];
  int gused, edis;

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Reference grouping from the requirements: first fit, fewest-fault sacrificial line.
  task automatic build_model();
    gused = 0;
    edis = 0;
    for (int i = 0; i < LINES; i++) begin
      int hit;
      int wt;
      hit = -1;
      wt = $countones(ev[i]);
      for (int g = 0; g < gused; g++)
        if (hit < 0 && gsize[g] < GRP_MAX && (gunion[g] & ev[i]) == '0) hit = g;
      if (hit < 0 && gused < GROUPS) begin
        hit = gused;
        gused++;
        gunion[hit] = '0;
        gsize[hit] = 0;
        gsac[hit] = i;
        gwt[hit] = wt;
      end else if (hit >= 0 && wt < gwt[hit]) begin
        gsac[hit] = i;
        gwt[hit] = wt;
      end
      if (hit < 0) begin
        ed[i] = 1'b1; eg[i] = 0; edis++;
      end else begin
        ed[i] = 1'b0; eg[i] = hit;
        gunion[hit] = gunion[hit] | ev[i];
        gsize[hit]++;
      end
    end
  endtask

  function automatic logic [CHUNKS-1:0] cover_of(int g);
    logic [CHUNKS-1:0] c;
    c = '0;
    for (int j = 0; j < LINES; j++)
      if (!ed[j] && eg[j] == g && j != gsac[g]) c = c | ev[j];
    return c;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; lp_req = 0; bist_done = 0; hp_ack = 0; flt_valid = 0;
    mm_ready = 0; fm_ready = 0; flt_vec = '0; vdd_mv = 12'd600;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic threshold_case(int mv);
    do_reset();
    vdd_mv = VW'(mv);
    lp_req = 1'b1;
    @(negedge clk);
    lp_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk_eq("R1", "no test at high supply", int'(bist_start), 0);
    end
    chk_eq("R12", "remap off before build", int'(remap_en), 0);
  endtask

  task automatic run_case(string nm);
    int idx;
    bit pulsed;
    build_model();
    do_reset();
    chk_eq("R10", {nm, " reset done"}, int'(done), 0);
    chk_eq("R1", {nm, " reset ready"}, int'(flt_ready), 0);
    chk_eq("R8", {nm, " reset mm_valid"}, int'(mm_valid), 0);
    lp_req = 1'b1;
    @(negedge clk);
    lp_req = 1'b0;
    chk_eq("R1", {nm, " test started"}, int'(bist_start), 1);
    repeat (2) @(negedge clk);
    chk_eq("R1", {nm, " wait for test"}, int'(hp_req), 0);
    bist_done = 1'b1;
    @(negedge clk);
    bist_done = 1'b0;
    chk_eq("R1", {nm, " wake requested"}, int'(hp_req), 1);
    chk_eq("R1", {nm, " test released"}, int'(bist_start), 0);
    @(negedge clk);
    chk_eq("R1", {nm, " no intake before ack"}, int'(flt_ready), 0);
    hp_ack = 1'b1;
    @(negedge clk);
    hp_ack = 1'b0;
    chk_eq("R1", {nm, " intake open"}, int'(flt_ready), 1);

    idx = 0;
    pulsed = 1'b0;
    while (idx < LINES) begin
      @(negedge clk);
      lp_req = 1'b0;
      if (!pulsed && idx == LINES / 2) begin lp_req = 1'b1; pulsed = 1'b1; end
      flt_valid = ($urandom % 4) != 0;
      flt_vec = ev[idx];
      #1;
      if (flt_valid && flt_ready) idx++;
    end
    @(negedge clk);
    flt_valid = 1'b0;
    lp_req = 1'b0;
    chk_eq("R11", {nm, " mid-build request ignored"}, int'(bist_start), 0);

    idx = 0;
    while (idx < LINES) begin
      @(negedge clk);
      mm_ready = ($urandom % 3) != 0;
      if (idx == 3) lp_req = 1'b1; else lp_req = 1'b0;
      #1;
      if (mm_valid && mm_ready) begin
        chk_eq("R8", {nm, " mm line order"}, int'(mm_line), idx);
        chk_eq("R6", {nm, " mm disabled"}, int'(mm_dis), int'(ed[idx]));
        if (!ed[idx]) begin
          chk_eq(ev[idx] == '0 ? "R5" : "R3", {nm, " mm group"}, int'(mm_group), eg[idx]);
          chk_eq("R7", {nm, " mm sacrificial"}, int'(mm_sac), int'(gsac[eg[idx]] == idx));
        end
        chk_eq("R10", {nm, " done early"}, int'(done), 0);
        idx++;
      end
    end
    lp_req = 1'b0;

    idx = 0;
    while (idx < gused) begin
      @(negedge clk);
      mm_ready = 1'b0;
      fm_ready = ($urandom % 3) != 0;
      #1;
      if (fm_valid && fm_ready) begin
        chk_eq("R9", {nm, " fm group order"}, int'(fm_grp), idx);
        chk_eq("R7", {nm, " fm sacrificial"}, int'(fm_sac_line), gsac[idx]);
        chk_eq("R9", {nm, " fm cover"}, int'(fm_cover), int'(cover_of(idx)));
        chk_eq("R10", {nm, " done early"}, int'(done), 0);
        idx++;
      end
    end
    @(negedge clk);
    fm_ready = 1'b0;
    chk_eq("R10", {nm, " done raised"}, int'(done), 1);
    chk_eq("R6", {nm, " disabled count"}, int'(dis_count), edis);
    chk_eq("R11", {nm, " no test during build"}, int'(bist_start), 0);
    lp_req = 1'b1;
    @(negedge clk);
    lp_req = 1'b0;
    @(negedge clk);
    chk_eq("R10", {nm, " done sticky"}, int'(done), 1);
    chk_eq("R10", {nm, " no retest"}, int'(bist_start), 0);
    chk_eq("R12", {nm, " remap below limit"}, int'(remap_en), 1);
    vdd_mv = 12'd651;
    #1;
    chk_eq("R12", {nm, " remap at limit"}, int'(remap_en), 0);
    vdd_mv = 12'd650;
    #1;
    chk_eq("R12", {nm, " remap just below"}, int'(remap_en), 1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    threshold_case(700);
    threshold_case(651);

    for (int i = 0; i < LINES; i++) ev[i] = '0;
    run_case("all clean R4 R5");

    for (int i = 0; i < LINES; i++) ev[i] = 8'h01;
    run_case("same chunk R6");

    ev[0] = 8'h03; ev[1] = 8'h04; ev[2] = 8'h08; ev[3] = 8'h00;
    ev[4] = 8'h10; ev[5] = 8'h01; ev[6] = 8'h30; ev[7] = 8'hC0;
    ev[8] = 8'h02; ev[9] = 8'h00; ev[10] = 8'h05; ev[11] = 8'h48;
    ev[12] = 8'h80; ev[13] = 8'hFF; ev[14] = 8'h01; ev[15] = 8'h20;
    run_case("directed R7 ties");

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < LINES; i++)
        for (int b = 0; b < CHUNKS; b++) ev[i][b] = (($urandom % 5) == 0);
      run_case("random R2 R3");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule